// File: doc/BRIEF.md
# Boundary-Scan Instruction Register

This block holds the instruction of a boundary-scan test access port. It has two stages. A 5-bit shift stage is loaded with a fixed pattern during the capture state and shifted serially from the test data input during the shift state. A 5-bit output stage holds the active instruction and is copied from the shift stage only during the update state. An external TAP controller drives four one-hot state flags into the block: capture, shift, update and test-logic-reset.

The serial output presents the shift stage's least significant bit. The active instruction is decoded into a one-hot select for the data registers. The fixed capture pattern is itself the sample/preload opcode. A capture followed directly by an update, with no shift in between, therefore makes sample/preload the active instruction. The output stage changes on the falling edge of the test clock, so the active instruction is stable around each rising edge, where the data registers act.

Top module: `ir_stage`

## Requirements
- R1: The shift stage is 5 bits wide with no parity bit. On a rising test clock edge in the capture state it loads 00001 (bit 0 = 1, bits 4..1 = 0).
- R2: On each rising test clock edge in the shift state, the shift stage moves one bit toward the serial output, and its bit 4 is taken from the serial input. The serial output always shows bit 0 of the shift stage.
- R3: The output stage takes the shift stage's value only on a falling test clock edge in the update state. In every other state the active instruction holds its value, including during capture and shift.
- R4: A capture followed by an update, with no shift between them, makes 00001 (sample/preload) the active instruction.
- R5: On a falling test clock edge in the test-logic-reset state, the active instruction becomes 11111 (bypass). This takes priority over the update flag.
- R6: While the active-low test reset is low, the active instruction is forced to 11111 and the shift stage to 00001. This happens at once, without a clock edge.
- R7: The data-register select is one-hot: bit 0 for bypass (11111), bit 1 for sample/preload (00001), bit 2 for external test (00000) and bit 3 for identification (00010).
- R8: Any active-instruction value other than 00001, 00000 and 00010 sets select bit 0 (bypass).
- R9: When neither the capture nor the shift flag is set, the shift stage keeps its value across rising edges, regardless of the serial input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Serial test data in |
| st_reset | input | 1 | TAP controller is in test-logic-reset |
| st_capture | input | 1 | TAP controller is in capture-IR |
| st_shift | input | 1 | TAP controller is in shift-IR |
| st_update | input | 1 | TAP controller is in update-IR |
| tdo | output | 1 | Serial data out, bit 0 of the shift stage |
| instr | output | 5 | Active instruction (output stage) |
| dr_sel | output | 4 | One-hot data-register select |

## Verification
The bench checks that the capture pattern comes out on the serial output before the shifted opcode does. A design that dropped the pattern or shifted in the wrong direction would show the wrong bit sequence there. It checks that the active instruction stays unchanged through capture and shift. A design that let the shift stage drive the decode would change the select partway through a scan. It runs capture-then-update with no shift, to catch a design whose capture pattern is not sample/preload. It also checks unrecognised opcodes, test-logic-reset asserted together with update, and an asynchronous reset in mid-cycle. A wrong decode default, a wrong priority or a synchronous-only reset would leave an instruction other than bypass active.

// File: rtl/ir_stage.sv
module ir_stage #(
  parameter int          IR_W      = 5,
  parameter logic [IR_W-1:0] OP_BYPASS = 5'b11111,
  parameter logic [IR_W-1:0] OP_SAMPLE = 5'b00001,
  parameter logic [IR_W-1:0] OP_EXTEST = 5'b00000,
  parameter logic [IR_W-1:0] OP_IDCODE = 5'b00010,
  parameter logic [IR_W-1:0] CAP_PAT   = 5'b00001,
  parameter int          SEL_W     = 4
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tdi,
  input  logic             st_reset,
  input  logic             st_capture,
  input  logic             st_shift,
  input  logic             st_update,
  output logic             tdo,
  output logic [IR_W-1:0]  instr,
  output logic [SEL_W-1:0] dr_sel
);

  logic [IR_W-1:0] shreg;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)         shreg <= CAP_PAT;
    else if (st_capture) shreg <= CAP_PAT;
    else if (st_shift)   shreg <= {tdi, shreg[IR_W-1:1]};
  end

  assign tdo = shreg[0];

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)        instr <= OP_BYPASS;
    else if (st_reset)  instr <= OP_BYPASS;
    else if (st_update) instr <= shreg;
  end

  always_comb begin
    dr_sel = '0;
    unique case (instr)
      OP_SAMPLE: dr_sel[1] = 1'b1;
      OP_EXTEST: dr_sel[2] = 1'b1;
      OP_IDCODE: dr_sel[3] = 1'b1;
      default:   dr_sel[0] = 1'b1;
    endcase
  end

  a_r1_capture_pattern: assert property (@(posedge tck) disable iff (!trst_n)
    st_capture |=> (tdo == 1'b1) && (shreg[IR_W-1:1] == '0));

  a_r2_shift_toward_tdo: assert property (@(posedge tck) disable iff (!trst_n)
    (st_shift && !st_capture) |=> (tdo == $past(shreg[1])) && (shreg[IR_W-1] == $past(tdi)));

  a_r9_hold_shift_stage: assert property (@(posedge tck) disable iff (!trst_n)
    (!st_shift && !st_capture) |=> $stable(tdo));

  a_r3_hold_instr: assert property (@(negedge tck) disable iff (!trst_n)
    (!st_update && !st_reset) |=> $stable(instr));

  a_r3_update_copy: assert property (@(negedge tck) disable iff (!trst_n)
    (st_update && !st_reset) |=> instr == $past(shreg));

  a_r5_reset_state: assert property (@(negedge tck) disable iff (!trst_n)
    st_reset |=> instr == OP_BYPASS);

  a_r7_onehot_select: assert property (@(posedge tck) disable iff (!trst_n)
    $countones(dr_sel) == 1);

  a_r8_default_bypass: assert property (@(posedge tck) disable iff (!trst_n)
    (instr != OP_SAMPLE && instr != OP_EXTEST && instr != OP_IDCODE) |-> dr_sel[0]);

endmodule

// File: tb/test_ir_stage.sv
module test_ir_stage;
  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tdi = 1'b0;
  logic st_reset = 1'b0, st_capture = 1'b0, st_shift = 1'b0, st_update = 1'b0;
  logic tdo;
  logic [4:0] instr;
  logic [3:0] dr_sel;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 tck = ~tck;

  ir_stage i_ir_stage (
    .tck(tck), .trst_n(trst_n), .tdi(tdi),
    .st_reset(st_reset), .st_capture(st_capture), .st_shift(st_shift), .st_update(st_update),
    .tdo(tdo), .instr(instr), .dr_sel(dr_sel)
  );

  // opcode[8:4], expected select[3:0]
  localparam logic [8:0] VEC [8] = '{
    {5'b00000, 4'b0100}, {5'b00001, 4'b0010}, {5'b00010, 4'b1000}, {5'b11111, 4'b0001},
    {5'b10101, 4'b0001}, {5'b00011, 4'b0001}, {5'b01110, 4'b0001}, {5'b10000, 4'b0001}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one controller state: drive after a falling edge, span a rising then a falling edge
  task automatic step(input logic c, input logic s, input logic u, input logic r, input logic d);
    st_capture = c; st_shift = s; st_update = u; st_reset = r; tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic load(input logic [4:0] op, input logic [4:0] prev);
    logic [9:0] stream;
    stream = {op, 5'b00001};
    step(1, 0, 0, 0, 0);
    chk("R1 tdo after capture", {7'b0, tdo}, 8'd1);
    chk("R3 instr held in capture", {3'b0, instr}, {3'b0, prev});
    for (int k = 0; k < 5; k++) begin
      step(0, 1, 0, 0, op[k]);
      chk("R2 tdo during shift", {7'b0, tdo}, {7'b0, stream[k+1]});
    end
    chk("R3 instr held in shift", {3'b0, instr}, {3'b0, prev});
    step(0, 0, 1, 0, 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [4:0] prev;
    @(negedge tck); #1;
    chk("R6 instr in reset", {3'b0, instr}, 8'b00011111);
    chk("R7 select in reset", {4'b0, dr_sel}, 8'b0001);
    chk("R6 tdo in reset", {7'b0, tdo}, 8'd1);
    trst_n = 1'b1;
    step(0, 0, 0, 0, 0);

    prev = 5'b11111;
    foreach (VEC[i]) begin
      load(VEC[i][8:4], prev);
      chk("R3 instr after update", {3'b0, instr}, {3'b0, VEC[i][8:4]});
      chk("R7 R8 select decode", {4'b0, dr_sel}, {4'b0, VEC[i][3:0]});
      prev = VEC[i][8:4];
    end

    // R4: capture then update, no shift
    load(5'b00010, prev);
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    chk("R4 capture-update gives sample", {3'b0, instr}, 8'b00000001);
    chk("R4 select sample", {4'b0, dr_sel}, 8'b0010);

    // R9: shift stage holds with no capture/shift, tdi toggling
    load(5'b00000, 5'b00001);
    for (int k = 0; k < 4; k++) begin
      step(0, 0, 0, 0, k[0]);
      chk("R9 tdo holds when idle", {7'b0, tdo}, 8'd0);
    end
    step(0, 0, 1, 0, 0);
    chk("R9 idle cycles kept value", {3'b0, instr}, 8'b00000000);

    // R5: reset state wins over update
    step(0, 0, 1, 1, 0);
    chk("R5 reset state forces bypass", {3'b0, instr}, 8'b00011111);
    chk("R5 select bypass", {4'b0, dr_sel}, 8'b0001);

    // R6: asynchronous reset mid-cycle
    load(5'b00010, 5'b11111);
    for (int k = 0; k < 5; k++) step(0, 1, 0, 0, 1'b0);
    @(posedge tck); #1;
    trst_n = 1'b0;
    #0.5;
    chk("R6 async reset instr", {3'b0, instr}, 8'b00011111);
    chk("R6 async reset shift stage", {7'b0, tdo}, 8'd1);
    @(negedge tck); #1;
    trst_n = 1'b1;
    step(0, 0, 1, 0, 0);
    chk("R6 update after reset gives pattern", {3'b0, instr}, 8'b00000001);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule